// File: doc/BRIEF.md
# SDRAM Single-Bank Write Transaction Sequencer

This block drives the command, address, bank and data pins of a synchronous DRAM to carry out one write transaction. It takes a request with a bank, a row, a column, four data words and a precharge-scope flag. It then opens the row, issues a write with auto precharge turned off, and drives a four-beat burst. After the write-recovery wait it closes the bank with an explicit precharge command. It holds off the next row opening until the precharge period and the full row cycle have both run out.

All memory timing limits are parameters counted in clock cycles. To get each one, divide the nanosecond figure by the clock period and round up. The write-recovery limit is a fixed time in nanoseconds, so its cycle count has to be worked out again for every clock frequency. A one-cycle done pulse marks the last cycle of a transaction. A request that is held high through that cycle is accepted at once, so back-to-back writes have no idle gap.

Top module: `sdram_wr_seq`

## Requirements
- R1: While reset is asserted and after it, with no request, the pins show NOP, `dq_oe` is 0, `dqm` is 1, `done` is 0, and `addr`, `ba`, `dq_out` are 0.
- R2: The command is encoded on {`cs_n`,`ras_n`,`cas_n`,`we_n`} as follows: ACTIVE = 0011, WRITE = 0100, PRECHARGE = 0010, NOP = 0111. Call the cycle after the clock edge that accepts a request relative cycle 0. In relative cycle 0 the pins show ACTIVE, with `ba` = bank and `addr` = row.
- R3: WRITE appears exactly `T_RCD` cycles after ACTIVE. It carries the column on `addr[COL_W-1:0]`, `addr[10]` = 0 (auto precharge off), every other address bit 0, and `ba` = bank.
- R4: `dq_oe` is 1 and `dqm` is 0 in the WRITE cycle and the three cycles after it. In those cycles `dq_out` carries beat k = `req_data[k*DQ_W +: DQ_W]`, with k counting 0 to 3 from the WRITE cycle. In all other cycles `dq_oe` = 0, `dqm` = 1 and `dq_out` = 0.
- R5: PRECHARGE appears at relative cycle P = max(`T_RCD`+3+`T_WR`, `T_RAS`). This keeps at least `T_WR` cycles after the last beat and at least `T_RAS` cycles after ACTIVE. `addr[10]` carries the request's all-banks flag (1 = all banks, 0 = only bank `ba`), `ba` = bank, and the other address bits are 0.
- R6: `done` is high for exactly one cycle, at relative cycle max(P+`T_RP`, `T_RC`)-1. A request present in that cycle is accepted, so the next ACTIVE lands exactly at max(P+`T_RP`, `T_RC`).
- R7: A request that arrives while a transaction is under way, outside its done cycle, is ignored. It causes no extra ACTIVE and does not change the address, bank or data of the transaction in progress.
- R8: Every cycle that is not an ACTIVE, WRITE or PRECHARGE cycle under R2, R3 and R5 shows NOP, with `addr` and `ba` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| req_bank | input | BANK_W | Bank to write |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column of the burst |
| req_data | input | 4*DQ_W | Four burst words, beat 0 in the low bits |
| req_all_banks | input | 1 | Precharge scope: 1 closes all banks |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Multiplexed address pins |
| ba | output | BANK_W | Bank select pins |
| dq_out | output | DQ_W | Write data |
| dq_oe | output | 1 | Data output enable |
| dqm | output | 1 | Data mask, high masks |
| done | output | 1 | Last-cycle pulse of the transaction |

## Verification
Every pin is due a fixed number of cycles after the accepting edge: ACTIVE at relative cycle 0, WRITE at `T_RCD`, beats at `T_RCD` to `T_RCD`+3, PRECHARGE at P, and done at max(P+`T_RP`, `T_RC`)-1. A behavioural reference model advances on the same rising edge as the design. It computes each of these offsets from its own arithmetic and tracks the burst words in a queue. The bench compares every output with the model at each falling edge. Two instances are checked: one where write recovery sets the precharge point, and one where the row-active time and row cycle dominate. Both get single, ignored and back-to-back requests.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  localparam int BURST    = 4;
  localparam int AP_BIT   = 10;

  // Relative cycle of PRECHARGE: recovery after last beat versus row-active minimum
  function automatic int pre_offset(int rcd, int wr, int ras);
    int v;
    v = rcd + BURST - 1 + wr;
    return (ras > v) ? ras : v;
  endfunction

  // Relative cycle of the final (done) cycle of a transaction
  function automatic int last_offset(int rcd, int wr, int ras, int rp, int rc);
    int v;
    v = pre_offset(rcd, wr, ras) + rp;
    if (rc > v) v = rc;
    return v - 1;
  endfunction

endpackage

// File: rtl/sdram_wr_timer.sv
module sdram_wr_timer
  import sdram_wr_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_WR  = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_RC  = 9,
  localparam int IDX_W = $clog2(BURST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             accept,
  output logic             ev_act,
  output logic             ev_wr,
  output logic             ev_beat,
  output logic [IDX_W-1:0] beat_idx,
  output logic             ev_pre,
  output logic             ev_last
);
  localparam int PRE_T  = pre_offset(T_RCD, T_WR, T_RAS);
  localparam int LAST_T = last_offset(T_RCD, T_WR, T_RAS, T_RP, T_RC);
  localparam int CNT_W  = $clog2(LAST_T + 1) < IDX_W ? IDX_W : $clog2(LAST_T + 1);

  logic             busy;
  logic [CNT_W-1:0] t;

  assign ev_act   = busy && (t == CNT_W'(0));
  assign ev_wr    = busy && (t == CNT_W'(T_RCD));
  assign ev_beat  = busy && (t >= CNT_W'(T_RCD)) && (t <= CNT_W'(T_RCD + BURST - 1));
  assign beat_idx = IDX_W'(t - CNT_W'(T_RCD));
  assign ev_pre   = busy && (t == CNT_W'(PRE_T));
  assign ev_last  = busy && (t == CNT_W'(LAST_T));
  assign accept   = req_valid && (!busy || ev_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      t    <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      t    <= '0;
    end else if (ev_last) begin
      busy <= 1'b0;
      t    <= '0;
    end else if (busy) begin
      t <= t + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sdram_wr_capture.sv
module sdram_wr_capture
  import sdram_wr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 16,
  localparam int IDX_W  = $clog2(BURST),
  localparam int DATA_W = BURST * DQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_all_banks,
  input  logic [IDX_W-1:0]  beat_idx,
  output logic [BANK_W-1:0] bank_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic              all_q,
  output logic [DQ_W-1:0]   beat_word
);
  logic [DATA_W-1:0] data_q;
  logic [DQ_W-1:0]   words [BURST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      all_q  <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
      all_q  <= req_all_banks;
      data_q <= req_data;
    end
  end

  for (genvar k = 0; k < BURST; k++) begin : g_word
    assign words[k] = data_q[k*DQ_W +: DQ_W];
  end

  assign beat_word = words[beat_idx];

endmodule

// File: rtl/sdram_wr_pins.sv
module sdram_wr_pins
  import sdram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 16
) (
  input  logic              ev_act,
  input  logic              ev_wr,
  input  logic              ev_beat,
  input  logic              ev_pre,
  input  logic [BANK_W-1:0] bank_q,
  input  logic [ROW_W-1:0]  row_q,
  input  logic [COL_W-1:0]  col_q,
  input  logic              all_q,
  input  logic [DQ_W-1:0]   beat_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              dqm
);
  sdram_cmd_e cmd;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    if (ev_act) begin
      cmd  = CMD_ACT;
      addr = ADDR_W'(row_q);
      ba   = bank_q;
    end else if (ev_wr) begin
      cmd               = CMD_WR;
      addr[COL_W-1:0]   = col_q;
      addr[AP_BIT]      = 1'b0;
      ba                = bank_q;
    end else if (ev_pre) begin
      cmd          = CMD_PRE;
      addr[AP_BIT] = all_q;
      ba           = bank_q;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign dq_oe  = ev_beat;
  assign dqm    = !ev_beat;
  assign dq_out = ev_beat ? beat_word : '0;

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 16,
  parameter int T_RCD  = 3,
  parameter int T_WR   = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_RC   = 9,
  localparam int IDX_W  = $clog2(BURST),
  localparam int DATA_W = BURST * DQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_all_banks,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              dqm,
  output logic              done
);
  logic             accept;
  logic             ev_act, ev_wr, ev_beat, ev_pre, ev_last;
  logic [IDX_W-1:0] beat_idx;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              all_q;
  logic [DQ_W-1:0]   beat_word;

  sdram_wr_timer #(
    .T_RCD(T_RCD), .T_WR(T_WR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .accept(accept),
    .ev_act(ev_act), .ev_wr(ev_wr), .ev_beat(ev_beat), .beat_idx(beat_idx),
    .ev_pre(ev_pre), .ev_last(ev_last)
  );

  sdram_wr_capture #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_data(req_data), .req_all_banks(req_all_banks), .beat_idx(beat_idx),
    .bank_q(bank_q), .row_q(row_q), .col_q(col_q), .all_q(all_q),
    .beat_word(beat_word)
  );

  sdram_wr_pins #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)
  ) u_pins (
    .ev_act(ev_act), .ev_wr(ev_wr), .ev_beat(ev_beat), .ev_pre(ev_pre),
    .bank_q(bank_q), .row_q(row_q), .col_q(col_q), .all_q(all_q),
    .beat_word(beat_word),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .dq_out(dq_out), .dq_oe(dq_oe), .dqm(dqm)
  );

  assign done = ev_last;

endmodule

// File: rtl/sdram_wr_seq_chk.sv
module sdram_wr_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int T_RCD  = 3,
  parameter int T_WR   = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_RC   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_oe,
  input logic              dqm,
  input logic              done,
  input logic              accept
);
  logic [3:0]  cmd;
  logic [15:0] since_act, since_pre, since_oe;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  function automatic logic [15:0] sat_inc(logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  // Cycles since the last ACTIVE, PRECHARGE and enabled data beat (saturating)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 16'hFFFF;
      since_pre <= 16'hFFFF;
      since_oe  <= 16'hFFFF;
    end else begin
      since_act <= (cmd == 4'b0011) ? 16'd1 : sat_inc(since_act);
      since_pre <= (cmd == 4'b0010) ? 16'd1 : sat_inc(since_pre);
      since_oe  <= dq_oe ? 16'd1 : sat_inc(since_oe);
    end
  end

  a_r2_act_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0011) |-> $past(accept));

  a_r3_write_at_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0100) |-> (since_act == 16'(T_RCD) && addr[10] == 1'b0));

  a_r4_beats_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !dqm);

  a_r5_pre_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (since_act >= 16'(T_RAS)));

  a_r5_pre_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> (since_oe >= 16'(T_WR)));

  a_r6_act_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0011) |-> (since_pre >= 16'(T_RP)));

  a_r6_act_after_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0011) |-> (since_act >= 16'(T_RC)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
  .ADDR_W(ADDR_W), .T_RCD(T_RCD), .T_WR(T_WR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RC(T_RC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .dq_oe(dq_oe), .dqm(dqm), .done(done), .accept(accept)
);

// File: tb/tb_sdram_wr_seq.sv
`timescale 1ns/1ps

module sdram_wr_ref #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 16,
  parameter int T_RCD  = 3,
  parameter int T_WR   = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_RC   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [4*DQ_W-1:0] req_data,
  input  logic              req_all_banks,
  output logic [3:0]        e_cmd,
  output logic [ADDR_W-1:0] e_addr,
  output logic [BANK_W-1:0] e_ba,
  output logic [DQ_W-1:0]   e_dq,
  output logic              e_oe,
  output logic              e_dqm,
  output logic              e_done
);
  localparam int WR_END   = T_RCD + 3 + T_WR;
  localparam int PRE_AT   = (T_RAS > WR_END) ? T_RAS : WR_END;
  localparam int NEXT_ACT = (T_RC > PRE_AT + T_RP) ? T_RC : PRE_AT + T_RP;

  int cyc, act_cyc, rel;
  bit busy;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              all;
  logic [DQ_W-1:0]   beats [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0; cyc = 0; act_cyc = 0;
      beats.delete();
    end else begin
      rel = cyc - act_cyc;
      if (busy && rel >= T_RCD && rel < T_RCD + 4) void'(beats.pop_front());
      cyc++;
      if (req_valid && (!busy || rel == NEXT_ACT - 1)) begin
        busy = 1; act_cyc = cyc;
        bank = req_bank; row = req_row; col = req_col; all = req_all_banks;
        beats.delete();
        for (int k = 0; k < 4; k++) beats.push_back(req_data[k*DQ_W +: DQ_W]);
      end else if (busy && rel == NEXT_ACT - 1) begin
        busy = 0;
      end
    end
    e_cmd = 4'b0111; e_addr = '0; e_ba = '0; e_dq = '0;
    e_oe = 0; e_dqm = 1; e_done = 0;
    if (busy) begin
      rel = cyc - act_cyc;
      if (rel == 0) begin
        e_cmd = 4'b0011; e_addr = ADDR_W'(row); e_ba = bank;
      end else if (rel == T_RCD) begin
        e_cmd = 4'b0100; e_addr = ADDR_W'(col); e_ba = bank;
      end else if (rel == PRE_AT) begin
        e_cmd = 4'b0010; e_addr = ADDR_W'(all) << 10; e_ba = bank;
      end
      if (rel >= T_RCD && rel < T_RCD + 4) begin
        e_oe = 1; e_dqm = 0; e_dq = beats[0];
      end
      if (rel == NEXT_ACT - 1) e_done = 1;
    end
  end
endmodule

module tb_sdram_wr_seq;
  localparam int DQ_W = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic [63:0] req_data = '0;
  logic        req_all_banks = 0;

  always #10 clk = ~clk;

  // index 0: default timing (recovery-bound), index 1: row-active/row-cycle bound
  logic        cs_n[2], ras_n[2], cas_n[2], we_n[2], dq_oe[2], dqm[2], done[2];
  logic [12:0] addr[2];
  logic [1:0]  ba[2];
  logic [15:0] dq_out[2];
  logic [3:0]  e_cmd[2];
  logic [12:0] e_addr[2];
  logic [1:0]  e_ba[2];
  logic [15:0] e_dq[2];
  logic        e_oe[2], e_dqm[2], e_done[2];

  sdram_wr_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_data(req_data), .req_all_banks(req_all_banks),
    .cs_n(cs_n[0]), .ras_n(ras_n[0]), .cas_n(cas_n[0]), .we_n(we_n[0]),
    .addr(addr[0]), .ba(ba[0]), .dq_out(dq_out[0]), .dq_oe(dq_oe[0]), .dqm(dqm[0]),
    .done(done[0])
  );

  sdram_wr_seq #(.T_RAS(12), .T_RC(16)) dut_ras (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_data(req_data), .req_all_banks(req_all_banks),
    .cs_n(cs_n[1]), .ras_n(ras_n[1]), .cas_n(cas_n[1]), .we_n(we_n[1]),
    .addr(addr[1]), .ba(ba[1]), .dq_out(dq_out[1]), .dq_oe(dq_oe[1]), .dqm(dqm[1]),
    .done(done[1])
  );

  sdram_wr_ref ref0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_data(req_data), .req_all_banks(req_all_banks),
    .e_cmd(e_cmd[0]), .e_addr(e_addr[0]), .e_ba(e_ba[0]), .e_dq(e_dq[0]),
    .e_oe(e_oe[0]), .e_dqm(e_dqm[0]), .e_done(e_done[0])
  );

  sdram_wr_ref #(.T_RAS(12), .T_RC(16)) ref1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_data(req_data), .req_all_banks(req_all_banks),
    .e_cmd(e_cmd[1]), .e_addr(e_addr[1]), .e_ba(e_ba[1]), .e_dq(e_dq[1]),
    .e_oe(e_oe[1]), .e_dqm(e_dqm[1]), .e_done(e_done[1])
  );

  int checks = 0, errors = 0;
  int acts_seen[2], acts_exp[2];
  bit cmp_on = 0, finished = 0;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'b0011: return "R2";
      4'b0100: return "R3";
      4'b0010: return "R5";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      for (int i = 0; i < 2; i++) begin
        string t;
        t = tag_of(e_cmd[i]);
        chk(t, "cmd", 64'({cs_n[i], ras_n[i], cas_n[i], we_n[i]}), 64'(e_cmd[i]));
        chk(t, "addr", 64'(addr[i]), 64'(e_addr[i]));
        chk(t, "ba", 64'(ba[i]), 64'(e_ba[i]));
        chk("R4", "dq_out", 64'(dq_out[i]), 64'(e_dq[i]));
        chk("R4", "dq_oe", 64'(dq_oe[i]), 64'(e_oe[i]));
        chk("R4", "dqm", 64'(dqm[i]), 64'(e_dqm[i]));
        chk("R6", "done", 64'(done[i]), 64'(e_done[i]));
        if ({cs_n[i], ras_n[i], cas_n[i], we_n[i]} == 4'b0011) acts_seen[i]++;
        if (e_cmd[i] == 4'b0011) acts_exp[i]++;
      end
    end
  end

  task automatic send(logic [1:0] b, logic [12:0] r, logic [9:0] c, logic [63:0] d, logic all);
    @(negedge clk);
    req_valid = 1; req_bank = b; req_row = r; req_col = c; req_data = d; req_all_banks = all;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    acts_seen[0] = 0; acts_seen[1] = 0; acts_exp[0] = 0; acts_exp[1] = 0;
    // R1: reset state on both instances
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R1", "cmd in reset", 64'({cs_n[i], ras_n[i], cas_n[i], we_n[i]}), 64'h7);
      chk("R1", "dq_oe in reset", 64'(dq_oe[i]), 64'h0);
      chk("R1", "dqm in reset", 64'(dqm[i]), 64'h1);
      chk("R1", "done in reset", 64'(done[i]), 64'h0);
      chk("R1", "addr in reset", 64'(addr[i]), 64'h0);
    end
    rst_n = 1;
    cmp_on = 1;
    idle(3);

    // single write, single-bank precharge
    send(2'd2, 13'h1ABC, 10'h155, 64'h4444_3333_2222_1111, 1'b0);
    idle(22);
    // single write, all-bank precharge, then an R7 request mid-transaction
    send(2'd1, 13'h0F0F, 10'h3FF, 64'hDEAD_BEEF_CAFE_F00D, 1'b1);
    idle(3);
    send(2'd3, 13'h1FFF, 10'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    idle(25);
    // back-to-back: request held high with a fresh payload every cycle (R6, R7)
    for (int n = 0; n < 45; n++) begin
      @(negedge clk);
      req_valid = 1;
      req_bank = 2'($urandom);
      req_row = 13'($urandom);
      req_col = 10'($urandom);
      req_data = {$urandom, $urandom};
      req_all_banks = 1'($urandom);
    end
    @(negedge clk);
    req_valid = 0;
    idle(30);
    for (int i = 0; i < 2; i++)
      chk("R7", "ACTIVE count", 64'(acts_seen[i]), 64'(acts_exp[i]));
    // R7: first instance expects 2 singles + ignored one + held stream of 45 cycles
    chk("R7", "ACTIVE count independent", 64'(acts_seen[0]), 64'(2 + (45 + 10) / 11));
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule